// File: doc/BRIEF.md
# Phase-Shifted Dual Half-Bridge Gate Generator

This block drives the four gates of a back-to-back converter built from two half-bridge legs. Each leg has a high-side and a low-side switch, and the two switches of a leg are driven as a complementary pair at constant frequency with a fixed duty ratio. An interlock gap, during which both switches of a leg are off, separates every hand-over between the two switches of a leg. Regulation comes only from the delay of one leg relative to the other. A compensator supplies that delay as a phase command in clock cycles, and the block picks it up once per switching period.

A direction input selects which leg leads. In step-down mode, leg 1 leads and leg 2 lags by the phase shift. In step-up mode the roles swap. The phase command is clamped to a range in which a change at a period boundary can only fall inside a low-side conduction interval. This keeps every interlock gap whole. Dropping the enable input, or asserting the active-low reset, removes all four gates at once.

Each leg follows a fixed pattern over a local time `t` that runs from 0 to PERIOD-1:
- both switches are off for `t < DEAD_CYC`;
- the high side is on for `DEAD_CYC <= t < DUTY_CYC`;
- both switches are off again for `DUTY_CYC <= t < DUTY_CYC+DEAD_CYC`;
- the low side is on for the rest of the period.

The gate outputs are registered. After the k-th rising clock edge with enable high (k counted from 0), the outputs show the pattern for cycle k.

Top module: `psGateGen`

## Requirements
- R1: While `rstN` is low, all four gate outputs are 0, whatever the other inputs are.
- R2: When `enable` is low, all four gates are 0 in the same cycle, without waiting for a clock edge. After `enable` rises, the period restarts at cycle k=0, and all gates stay 0 for cycles k < DEAD_CYC.
- R3: The high-side and low-side gates of one leg are never 1 together.
- R4: A gate turns on only after at least DEAD_CYC cycles in which both gates of its leg were 0. This holds at start-up and at period boundaries where the shift or the mode changes.
- R5: The period is PERIOD cycles. The leading leg's high-side gate is 1 at cycle k with k mod PERIOD = DEAD_CYC, and 0 one cycle earlier.
- R6: Every high-side pulse, in either leg, lasts exactly DUTY_CYC-DEAD_CYC cycles.
- R7: With `modeUp`=0 (step-down), leg 1 follows the pattern at t = k mod PERIOD. Leg 2 follows it at t = (k - s) mod PERIOD, where s is the applied shift.
- R8: With `modeUp`=1 (step-up), leg 2 follows the pattern at t = k mod PERIOD. Leg 1 follows it at t = (k - s) mod PERIOD.
- R9: The applied shift is s = min(`phaseCmd`, PERIOD-DUTY_CYC-DEAD_CYC-1).
- R10: `phaseCmd` is sampled only on the clock edge of a period's last cycle (k mod PERIOD = PERIOD-1) and on every edge while `enable` is low. A change at any other time has no effect before the next period.
- R11: `modeUp` is sampled under the same rule as R10. A direction change mid-run takes effect from the first cycle of the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timing unit |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low forces all gates off |
| modeUp | input | 1 | 0 = step-down (leg 1 leads), 1 = step-up (leg 2 leads) |
| phaseCmd | input | PH_W | Requested shift of the lagging leg, in cycles |
| leg1HiGate | output | 1 | Leg 1 high-side gate |
| leg1LoGate | output | 1 | Leg 1 low-side gate |
| leg2HiGate | output | 1 | Leg 2 high-side gate |
| leg2LoGate | output | 1 | Leg 2 low-side gate |

## Verification
Internal faults show up quickly at the gates.
- A period counter that is off by one shows within one period: the leading leg's high-side rise is no longer at cycle DEAD_CYC of each period.
- A wrong modulo in the delayed time moves the lagging leg's edges in the same period that the shift is applied.
- A latch that fires at the wrong cycle shows as a shift or direction change appearing mid-period instead of at the boundary.
- Broken saturation shows as a lagging leg whose low-side pulse jumps straight into its high side, which violates the interlock gap at the first boundary with a large command.

The sweep covers every command value in both directions, comparing the four gates cycle by cycle against an arithmetic model. Extra runs move the command and the direction mid-period and exactly at the boundary.

// File: rtl/psGatePkg.sv
package psGatePkg;

  // Strobes from the sequencer to the gate datapath.
  typedef struct packed {
    logic run;    // block enabled this cycle
    logic blank;  // start-up blanking of all gates
    logic latch;  // sample shift and direction on this edge
  } ctrlStrobe_t;

  // Drive pair for one half-bridge leg.
  typedef struct packed {
    logic hi;
    logic lo;
  } legDrive_t;

endpackage

// File: rtl/psGateCtrl.sv
module psGateCtrl
  import psGatePkg::*;
#(
  parameter int PERIOD   = 24,
  parameter int DEAD_CYC = 2,
  parameter int CNT_W    = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  output logic [CNT_W-1:0] phaseCnt,
  output ctrlStrobe_t      strobe
);

  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] DEAD_C = CNT_W'(DEAD_CYC);

  logic firstPeriod;
  logic atLast;

  assign atLast = (phaseCnt == LAST_C);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt    <= '0;
      firstPeriod <= 1'b1;
    end else if (!enable) begin
      phaseCnt    <= '0;
      firstPeriod <= 1'b1;
    end else begin
      phaseCnt <= atLast ? '0 : phaseCnt + 1'b1;
      if (atLast) firstPeriod <= 1'b0;
    end
  end

  always_comb begin
    strobe.run   = enable;
    strobe.latch = !enable || atLast;
    strobe.blank = firstPeriod && (phaseCnt < DEAD_C);
  end

endmodule

// File: rtl/psLegDecode.sv
module psLegDecode
  import psGatePkg::*;
#(
  parameter int DUTY_CYC = 10,
  parameter int DEAD_CYC = 2,
  parameter int CNT_W    = 5
) (
  input  logic [CNT_W-1:0] localTime,
  output legDrive_t        drive
);

  localparam logic [CNT_W-1:0] HI_START = CNT_W'(DEAD_CYC);
  localparam logic [CNT_W-1:0] HI_END   = CNT_W'(DUTY_CYC);
  localparam logic [CNT_W-1:0] LO_START = CNT_W'(DUTY_CYC + DEAD_CYC);

  always_comb begin
    drive.hi = (localTime >= HI_START) && (localTime < HI_END);
    drive.lo = (localTime >= LO_START);
  end

endmodule

// File: rtl/psGateDatapath.sv
module psGateDatapath
  import psGatePkg::*;
#(
  parameter int PERIOD   = 24,
  parameter int DUTY_CYC = 10,
  parameter int DEAD_CYC = 2,
  parameter int PH_W     = 5,
  parameter int CNT_W    = $clog2(PERIOD)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [CNT_W-1:0]      phaseCnt,
  input  logic                  modeUp,
  input  logic [PH_W-1:0]       phaseCmd,
  output legDrive_t [1:0]       legOut
);

  localparam int               PH_MAX     = PERIOD - DUTY_CYC - DEAD_CYC - 1;
  localparam logic [PH_W-1:0]  PH_MAX_CMD = PH_W'(PH_MAX);
  localparam logic [CNT_W-1:0] PH_MAX_CNT = CNT_W'(PH_MAX);
  localparam logic [CNT_W:0]   PER_X      = (CNT_W+1)'(PERIOD);

  logic [CNT_W-1:0]       satShift;
  logic [CNT_W-1:0]       shiftL;
  logic                   modeL;
  logic [CNT_W:0]         wrapSum;
  logic [CNT_W-1:0]       delayed;
  logic [1:0][CNT_W-1:0]  localTime;
  legDrive_t [1:0]        rawDrive;
  legDrive_t [1:0]        legQ;

  // Clamp the command so a boundary change stays inside low-side conduction.
  always_comb begin
    if (phaseCmd > PH_MAX_CMD) satShift = PH_MAX_CNT;
    else                       satShift = CNT_W'(phaseCmd);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftL <= '0;
      modeL  <= 1'b0;
    end else if (strobe.latch) begin
      shiftL <= satShift;
      modeL  <= modeUp;
    end
  end

  // Local time of the lagging leg: (count - shift) mod PERIOD.
  always_comb begin
    wrapSum = {1'b0, phaseCnt} + PER_X - {1'b0, shiftL};
    if (wrapSum >= PER_X) delayed = CNT_W'(wrapSum - PER_X);
    else                  delayed = CNT_W'(wrapSum);
    localTime[0] = modeL ? delayed  : phaseCnt;
    localTime[1] = modeL ? phaseCnt : delayed;
  end

  for (genvar g = 0; g < 2; g++) begin : g_leg
    psLegDecode #(
      .DUTY_CYC (DUTY_CYC),
      .DEAD_CYC (DEAD_CYC),
      .CNT_W    (CNT_W)
    ) u_legDecode (
      .localTime (localTime[g]),
      .drive     (rawDrive[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            legQ <= '0;
    else if (!strobe.run || strobe.blank) legQ <= '0;
    else                                  legQ <= rawDrive;
  end

  assign legOut = legQ;

endmodule

// File: rtl/psGateGen.sv
module psGateGen
  import psGatePkg::*;
#(
  parameter int PERIOD   = 24,
  parameter int DUTY_CYC = 10,
  parameter int DEAD_CYC = 2,
  parameter int PH_W     = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            modeUp,
  input  logic [PH_W-1:0] phaseCmd,
  output logic            leg1HiGate,
  output logic            leg1LoGate,
  output logic            leg2HiGate,
  output logic            leg2LoGate
);

  localparam int CNT_W = $clog2(PERIOD);

  logic [CNT_W-1:0] phaseCnt;
  ctrlStrobe_t      strobe;
  legDrive_t [1:0]  legOut;

  psGateCtrl #(
    .PERIOD   (PERIOD),
    .DEAD_CYC (DEAD_CYC),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .phaseCnt (phaseCnt),
    .strobe   (strobe)
  );

  psGateDatapath #(
    .PERIOD   (PERIOD),
    .DUTY_CYC (DUTY_CYC),
    .DEAD_CYC (DEAD_CYC),
    .PH_W     (PH_W),
    .CNT_W    (CNT_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .phaseCnt (phaseCnt),
    .modeUp   (modeUp),
    .phaseCmd (phaseCmd),
    .legOut   (legOut)
  );

  // Enable gates the outputs directly so a stop takes effect at once.
  assign leg1HiGate = legOut[0].hi & enable;
  assign leg1LoGate = legOut[0].lo & enable;
  assign leg2HiGate = legOut[1].hi & enable;
  assign leg2LoGate = legOut[1].lo & enable;

endmodule

// File: rtl/psGateGenChk.sv
module psGateGenChk #(
  parameter int DEAD_CYC = 2
) (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic leg1Hi,
  input logic leg1Lo,
  input logic leg2Hi,
  input logic leg2Lo
);

  localparam int            OW     = $clog2(DEAD_CYC + 1) + 1;
  localparam logic [OW-1:0] DEAD_O = OW'(DEAD_CYC);

  logic [OW-1:0] offRun1;
  logic [OW-1:0] offRun2;

  // Consecutive cycles with both gates of a leg off, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offRun1 <= '0;
      offRun2 <= '0;
    end else begin
      if (leg1Hi || leg1Lo)     offRun1 <= '0;
      else if (offRun1 < DEAD_O) offRun1 <= offRun1 + 1'b1;
      if (leg2Hi || leg2Lo)     offRun2 <= '0;
      else if (offRun2 < DEAD_O) offRun2 <= offRun2 + 1'b1;
    end
  end

  p_idle_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !(leg1Hi || leg1Lo || leg2Hi || leg2Lo));

  p_leg1_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(leg1Hi && leg1Lo));

  p_leg2_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(leg2Hi && leg2Lo));

  p_leg1_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(leg1Hi) || $rose(leg1Lo)) |-> (offRun1 >= DEAD_O));

  p_leg2_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(leg2Hi) || $rose(leg2Lo)) |-> (offRun2 >= DEAD_O));

endmodule

bind psGateGen psGateGenChk #(.DEAD_CYC(DEAD_CYC)) i_psGateGenChk (
  .clk    (clk),
  .rstN   (rstN),
  .enable (enable),
  .leg1Hi (leg1HiGate),
  .leg1Lo (leg1LoGate),
  .leg2Hi (leg2HiGate),
  .leg2Lo (leg2LoGate)
);

// File: tb/test_psGateGen.sv
module test_psGateGen;

  localparam int P     = 24;
  localparam int D     = 10;
  localparam int DT    = 2;
  localparam int PW    = 5;
  localparam int PHMAX = P - D - DT - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b1;
  logic          modeUp = 1'b0;
  logic [PW-1:0] phaseCmd = 5'd5;
  logic          leg1HiGate, leg1LoGate, leg2HiGate, leg2LoGate;

  int  testsRun = 0;
  int  testsFailed = 0;
  bit  done = 1'b0;
  int  k;
  int  effPh;
  bit  effMode;
  int  offLen [2];
  int  hiLen  [2];
  bit  prevHi [2];

  wire [3:0] gates = {leg1HiGate, leg1LoGate, leg2HiGate, leg2LoGate};

  always #10 clk = ~clk;

  psGateGen #(.PERIOD(P), .DUTY_CYC(D), .DEAD_CYC(DT), .PH_W(PW)) i_psGateGen (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .modeUp     (modeUp),
    .phaseCmd   (phaseCmd),
    .leg1HiGate (leg1HiGate),
    .leg1LoGate (leg1LoGate),
    .leg2HiGate (leg2HiGate),
    .leg2LoGate (leg2LoGate)
  );

  function automatic int satPh(int c);
    return (c > PHMAX) ? PHMAX : c;
  endfunction

  function automatic logic [1:0] legPat(int t);
    logic hi, lo;
    hi = (t >= DT) && (t < D);
    lo = (t >= D + DT);
    return {hi, lo};
  endfunction

  function automatic logic [3:0] expGates(int kk, int ph, bit md);
    int t, d;
    if (kk < DT) return 4'b0000;
    t = kk % P;
    d = (t - ph + P) % P;
    return md ? {legPat(d), legPat(t)} : {legPat(t), legPat(d)};
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: k=%0d got %b expected %b", tag, k, act, exp);
    end
  endtask

  task automatic startRun(bit md, int cmd);
    @(negedge clk);
    enable   = 1'b0;
    modeUp   = md;
    phaseCmd = PW'(cmd);
    repeat (DT + 2) @(negedge clk);
    check("R2", gates, 4'b0000);
    enable  = 1'b1;
    k       = 0;
    effPh   = satPh(cmd);
    effMode = md;
    for (int g = 0; g < 2; g++) begin
      offLen[g] = DT;
      hiLen[g]  = 0;
      prevHi[g] = 1'b0;
    end
  endtask

  task automatic stepOne(string tag);
    logic [3:0] exp;
    logic       hi, lo, leadHi;
    @(negedge clk);
    exp = expGates(k, effPh, effMode);
    check((k < DT) ? "R2" : tag, gates, exp);
    // R3: exclusivity within each leg
    check("R3", {2'b00, gates[3] & gates[2], gates[1] & gates[0]}, 4'b0000);
    // R5: leading leg high side rises at cycle DT of each period
    leadHi = effMode ? gates[1] : gates[3];
    if (k % P == DT)     check("R5", {3'b000, leadHi}, 4'b0001);
    if (k % P == DT - 1) check("R5", {3'b000, leadHi}, 4'b0000);
    for (int g = 0; g < 2; g++) begin
      hi = gates[3 - 2*g];
      lo = gates[2 - 2*g];
      if ((hi || lo) && offLen[g] > 0 && offLen[g] < DT)
        check("R4", 4'b0001, 4'b0000);
      else if ((hi || lo) && offLen[g] >= DT && !prevHi[g] && hi)
        check("R4", 4'b0000, 4'b0000);
      if (prevHi[g] && !hi) check("R6", 4'(hiLen[g]), 4'(D - DT));
      hiLen[g]  = hi ? hiLen[g] + 1 : 0;
      offLen[g] = (hi || lo) ? 0 : offLen[g] + 1;
      prevHi[g] = hi;
    end
    if (k % P == P - 1) begin
      effPh   = satPh(int'(phaseCmd));
      effMode = modeUp;
    end
    k++;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    // R1: reset holds gates off even with enable high
    repeat (3) @(negedge clk);
    check("R1", gates, 4'b0000);
    rstN = 1'b1;

    // R7/R8/R9: sweep every command value in both directions
    for (int md = 0; md < 2; md++) begin
      for (int cmd = 0; cmd < (1 << PW); cmd++) begin
        startRun(md[0], cmd);
        repeat (2 * P)
          stepOne((cmd > PHMAX) ? "R9" : (md != 0 ? "R8" : "R7"));
      end
    end

    // R10: command change mid-period waits for the boundary
    startRun(1'b0, 3);
    repeat (P / 2) stepOne("R10");
    phaseCmd = 5'd9;
    repeat (P) stepOne("R10");
    // change right before the sampling edge of the last cycle
    while (k % P != P - 1) stepOne("R10");
    phaseCmd = 5'd1;
    repeat (2 * P) stepOne("R10");

    // R11: direction change mid-run, with shift at both extremes
    startRun(1'b0, PHMAX);
    repeat (P + 5) stepOne("R11");
    modeUp = 1'b1;
    repeat (2 * P) stepOne("R11");
    phaseCmd = 5'd0;
    modeUp   = 1'b0;
    repeat (2 * P) stepOne("R11");
    phaseCmd = 5'd31;
    repeat (2 * P) stepOne("R11");

    // R2: dropping enable removes gates without a clock edge
    startRun(1'b1, 4);
    repeat (P + 7) stepOne("R8");
    #3;
    enable = 1'b0;
    #1;
    check("R2", gates, 4'b0000);
    repeat (3) begin
      @(negedge clk);
      check("R2", gates, 4'b0000);
    end

    // R1: asynchronous reset mid-run while a high side is on
    startRun(1'b0, 0);
    repeat (DT + 1) stepOne("R7");
    check("R1", {3'b000, gates[3]}, 4'b0001);
    #5;
    rstN = 1'b0;
    #1;
    check("R1", gates, 4'b0000);
    @(negedge clk);
    check("R1", gates, 4'b0000);
    rstN = 1'b1;
    startRun(1'b1, 7);
    repeat (2 * P) stepOne("R8");

    summary();
  end

endmodule